// File: doc/BRIEF.md
# Serial Converter Interface Controller

This block is the digital front end of a multichannel successive-approximation converter with serial access. A host selects the device with an active-low chip select, clocks an 8-bit command in on a serial data line with a slow I/O clock, and at the same time receives the previous conversion result on a serial data output. The upper nibble of the command is the channel address or a power-down request. All three host inputs are brought into the system clock domain through two-flop synchronizers, and every edge is found there.

A valid address opens a sampling window at the fourth falling I/O clock edge. The window closes at the twelfth falling edge, and a conversion of fixed length then runs while end-of-conversion is low. The analog result arrives on a stub input and is captured into an output buffer when the conversion finishes. The buffer is shifted out MSB first. Shifting starts at the falling edge of chip select when chip select toggles between frames. When chip select stays low, it starts at the rising edge of end-of-conversion. The block starts in a sticky software power-down, and a later power-down command puts it back there. An automatic power-down flag shows when the converter is idle after a conversion.

Top module: `serial_adc_ctrl`

## Requirements
- R1: After reset, software power-down is active, eoc_o is high, sdo_o is low, auto_pd_o is low and the output buffer holds zero.
- R2: The command nibble is taken from sdi_i on the first four rising I/O clock edges, first bit as nibble bit 3. Nibble 4'b1110 sets sw_pd_o at the fourth falling edge, and the rest of that transfer still shifts out all 12 buffer bits.
- R3: Only a nibble other than 4'b1110 and 4'b1111 clears software power-down. Nibble 4'b1111 changes nothing and starts no conversion. While powered down, no conversion runs and the buffer keeps its last result.
- R4: For a valid nibble, sample_o is high from the fourth to the twelfth falling I/O clock edge, and chan_o shows the nibble.
- R5: After the twelfth falling edge of a valid command, eoc_o goes low and stays low for CONV_CYCLES system clocks. During that time sdo_o is low. At the end, result_i is stored in the buffer and eoc_o returns high.
- R6: On a falling cs_ni edge, sdo_o shows buffer bit 11. Each later falling I/O clock edge moves to the next lower bit. After the twelfth bit, sdo_o is low.
- R7: If cs_ni stays low through a conversion, sdo_o shows bit 11 of the new result once eoc_o rises, and the next transfer shifts that result out with no chip select edge.
- R8: A rising cs_ni edge ends any transfer or conversion in progress, and eoc_o is high afterwards. An aborted conversion leaves the buffer unchanged.
- R9: auto_pd_o is set when a conversion completes. It is cleared by a falling cs_ni edge or by a rising I/O clock edge while cs_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| ioclk_i | input | 1 | Serial I/O clock, asynchronous |
| sdi_i | input | 1 | Serial command input |
| result_i | input | RES_W | Converter result from the analog stub |
| sdo_o | output | 1 | Serial result output, MSB first |
| eoc_o | output | 1 | End of conversion, low while converting |
| sample_o | output | 1 | Sampling window active |
| chan_o | output | 4 | Last valid channel address |
| sw_pd_o | output | 1 | Software power-down active |
| auto_pd_o | output | 1 | Automatic power-down active |

## Verification
A wrong transfer count shows first on sample_o or eoc_o. It moves the point where the sampling window closes or where the conversion starts, and that is visible within one I/O clock period of the edge in question. A corrupted buffer or a wrong shift order shows in the bits read during the next transfer. A wrong power-down state shows either as a conversion where none should run (eoc_o low after a 1110 or 1111 command) or as a missing one. The effect appears within the same frame, or within a single conversion time at most.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_CONV = 2'd2
  } xfer_st_e;

  localparam logic [3:0] CMD_PWR_DOWN = 4'b1110;
  localparam logic [3:0] CMD_RESERVED = 4'b1111;
endpackage

// File: rtl/adc_ctrl_sync.sv
module adc_ctrl_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{RST_VAL[b]}};
      else         ff_q <= {ff_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned XFER_CLKS = 12,
  parameter int unsigned CMD_W = 4,
  parameter int unsigned CONV_CYCLES = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_s_i,
  input  logic             io_s_i,
  input  logic             sdi_s_i,
  output logic             sel_on_o,
  output logic             shift_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sample_o,
  output logic [CMD_W-1:0] chan_o,
  output logic             sw_pd_o,
  output logic             auto_pd_o
);
  localparam int unsigned RC_W = $clog2(CMD_W + 1);
  localparam int unsigned FC_W = $clog2(XFER_CLKS + 1);
  localparam int unsigned TM_W = $clog2(CONV_CYCLES + 1);

  xfer_st_e         state_q;
  logic             io_d_q, cs_d_q;
  logic [RC_W-1:0]  rise_cnt_q;
  logic [FC_W-1:0]  fall_cnt_q;
  logic [TM_W-1:0]  timer_q;
  logic [CMD_W-1:0] cmd_q, chan_q;
  logic             sampling_q, sw_pd_q, auto_pd_q, done_q;

  logic io_rise, io_fall, sel_on, sel_off;
  assign io_rise = io_s_i & ~io_d_q;
  assign io_fall = ~io_s_i & io_d_q;
  assign sel_on  = ~cs_n_s_i & cs_d_q;
  assign sel_off = cs_n_s_i & ~cs_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      io_d_q     <= 1'b0;
      cs_d_q     <= 1'b1;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
      timer_q    <= '0;
      cmd_q      <= '0;
      chan_q     <= '0;
      sampling_q <= 1'b0;
      sw_pd_q    <= 1'b1;
      auto_pd_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      io_d_q <= io_s_i;
      cs_d_q <= cs_n_s_i;
      done_q <= 1'b0;
      if (sel_on || (io_rise && !cs_n_s_i)) auto_pd_q <= 1'b0;
      if (sel_off) begin
        state_q    <= ST_IDLE;
        sampling_q <= 1'b0;
        timer_q    <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (sel_on) begin
              state_q    <= ST_XFER;
              rise_cnt_q <= '0;
              fall_cnt_q <= '0;
            end
          end
          ST_XFER: begin
            if (io_rise && rise_cnt_q < RC_W'(CMD_W)) begin
              cmd_q      <= {cmd_q[CMD_W-2:0], sdi_s_i};
              rise_cnt_q <= rise_cnt_q + 1'b1;
            end
            if (io_fall) begin
              // command decode on the last command bit's falling edge
              if (fall_cnt_q == FC_W'(CMD_W - 1)) begin
                if (cmd_q == CMD_PWR_DOWN) begin
                  sw_pd_q <= 1'b1;
                end else if (cmd_q != CMD_RESERVED) begin
                  sw_pd_q    <= 1'b0;
                  chan_q     <= cmd_q;
                  sampling_q <= 1'b1;
                end
              end
              if (fall_cnt_q == FC_W'(XFER_CLKS - 1)) begin
                sampling_q <= 1'b0;
                rise_cnt_q <= '0;
                fall_cnt_q <= '0;
                if (sampling_q) begin
                  state_q <= ST_CONV;
                  timer_q <= '0;
                end
              end else begin
                fall_cnt_q <= fall_cnt_q + 1'b1;
              end
            end
          end
          ST_CONV: begin
            if (timer_q == TM_W'(CONV_CYCLES - 1)) begin
              state_q   <= ST_XFER;
              timer_q   <= '0;
              done_q    <= 1'b1;
              auto_pd_q <= 1'b1;
            end else begin
              timer_q <= timer_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sel_on_o  = sel_on;
  assign shift_o   = io_fall && (state_q == ST_XFER);
  assign busy_o    = (state_q == ST_CONV);
  assign done_o    = done_q;
  assign sample_o  = sampling_q;
  assign chan_o    = chan_q;
  assign sw_pd_o   = sw_pd_q;
  assign auto_pd_o = auto_pd_q;

  a_r3_no_conv_in_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pd_q |-> state_q != ST_CONV);
  a_r4_sample_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampling_q |-> state_q == ST_XFER);
  a_r5_conv_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> timer_q < TM_W'(CONV_CYCLES));
  a_r8_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_off |=> state_q == ST_IDLE);
  a_r9_auto_pd_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> auto_pd_q);
endmodule

// File: rtl/adc_ctrl_out.sv
module adc_ctrl_out #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] res_i,
  input  logic             done_i,
  input  logic             sel_on_i,
  input  logic             shift_i,
  input  logic             busy_i,
  output logic             sdo_o
);
  logic [RES_W-1:0] buf_q, sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      sr_q  <= '0;
    end else if (done_i) begin
      buf_q <= res_i;
      sr_q  <= res_i;
    end else if (sel_on_i) begin
      sr_q <= buf_q;
    end else if (shift_i) begin
      sr_q <= {sr_q[RES_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sr_q[RES_W-1] & ~busy_i;

  a_r8_buf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(buf_q));
  a_r7_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> sr_q[RES_W-1] == $past(res_i[RES_W-1]));
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             ioclk_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             eoc_o,
  output logic             sample_o,
  output logic [3:0]       chan_o,
  output logic             sw_pd_o,
  output logic             auto_pd_o
);
  localparam int unsigned XFER_CLKS = RES_W;

  logic [2:0] pins_s;
  logic sel_on, shift, busy, done;

  adc_ctrl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, ioclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  adc_ctrl_seq #(.XFER_CLKS(XFER_CLKS), .CMD_W(4), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (pins_s[2]),
    .io_s_i   (pins_s[1]),
    .sdi_s_i  (pins_s[0]),
    .sel_on_o (sel_on),
    .shift_o  (shift),
    .busy_o   (busy),
    .done_o   (done),
    .sample_o (sample_o),
    .chan_o   (chan_o),
    .sw_pd_o  (sw_pd_o),
    .auto_pd_o(auto_pd_o)
  );

  adc_ctrl_out #(.RES_W(RES_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_i   (result_i),
    .done_i  (done),
    .sel_on_i(sel_on),
    .shift_i (shift),
    .busy_i  (busy),
    .sdo_o   (sdo_o)
  );

  assign eoc_o = ~busy;

  a_r5_sdo_low_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> !sdo_o);
endmodule

// File: tb/serial_adc_ctrl_tb_top.sv
module serial_adc_ctrl_tb_top;
  localparam int RES_W = 12;
  localparam int CONV = 40;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ioclk = 1'b0, sdi = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic sdo, eoc, sample, sw_pd, auto_pd;
  logic [3:0] chan;

  always #4 clk = ~clk;

  serial_adc_ctrl #(.RES_W(RES_W), .CONV_CYCLES(CONV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ioclk_i(ioclk), .sdi_i(sdi),
    .result_i(result), .sdo_o(sdo), .eoc_o(eoc), .sample_o(sample),
    .chan_o(chan), .sw_pd_o(sw_pd), .auto_pd_o(auto_pd)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [RES_W-1:0] buf_m = '0;
  logic pd_m = 1'b1;
  logic [RES_W-1:0] rd;
  logic pd4, samp4, eoc12, sdo12, samp12, apd_cs;
  logic [3:0] chan4;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit converts(input logic [3:0] c);
    return (c != 4'b1110) && (c != 4'b1111);
  endfunction

  task automatic run_frame(input logic [3:0] cmd, input bit cs_edge);
    if (cs_edge) begin
      cs_n = 1'b0;
      wait_cyc(H);
      apd_cs = auto_pd;
    end
    for (int i = 0; i < 12; i++) begin
      rd[11-i] = sdo;
      sdi = (i < 4) ? cmd[3-i] : 1'($urandom_range(0, 1));
      wait_cyc(2);
      ioclk = 1'b1;
      wait_cyc(H);
      ioclk = 1'b0;
      wait_cyc(H);
      if (i == 3) begin
        pd4 = sw_pd; samp4 = sample; chan4 = chan;
      end
    end
    eoc12 = eoc; sdo12 = sdo; samp12 = sample;
  endtask

  task automatic wait_eoc(output int cnt);
    cnt = 0;
    while (!eoc && cnt < 500) begin
      wait_cyc(1);
      cnt++;
    end
  endtask

  function automatic void model(input logic [3:0] cmd);
    if (cmd == 4'b1110) pd_m = 1'b1;
    else if (cmd != 4'b1111) pd_m = 1'b0;
  endfunction

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int cnt;
    logic [3:0] c;
    logic [RES_W-1:0] old;
    wait_cyc(3);
    // R1 reset state
    chk("R1 eoc", 32'(eoc), 1);
    chk("R1 sdo", 32'(sdo), 0);
    chk("R1 sw_pd", 32'(sw_pd), 1);
    chk("R1 auto_pd", 32'(auto_pd), 0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R2/R3 power-down command while down, buffer zero
    run_frame(4'b1110, 1);
    chk("R1 buffer zero", 32'(rd), 0);
    chk("R2 pd after 4th", 32'(pd4), 1);
    chk("R3 no conv in pd", 32'(eoc12), 1);
    cs_n = 1'b1; wait_cyc(H);

    // R3 reserved command keeps power-down
    run_frame(4'b1111, 1);
    chk("R3 reserved keeps pd", 32'(pd4), 1);
    chk("R3 reserved no conv", 32'(eoc12), 1);
    cs_n = 1'b1; wait_cyc(H);

    // R4/R5 valid channel
    result = 12'hA5C;
    run_frame(4'd5, 1); model(4'd5);
    chk("R3 valid clears pd", 32'(pd4), 0);
    chk("R4 sampling", 32'(samp4), 1);
    chk("R4 chan", 32'(chan4), 5);
    chk("R4 sample closed", 32'(samp12), 0);
    chk("R5 eoc low", 32'(eoc12), 0);
    chk("R5 sdo low", 32'(sdo12), 0);
    wait_eoc(cnt);
    chk("R5 conv length", 32'(cnt <= CONV && cnt >= CONV - H), 1);
    buf_m = result;
    wait_cyc(2);
    chk("R9 auto_pd set", 32'(auto_pd), 1);
    cs_n = 1'b1; wait_cyc(H);

    // R6 readout, R2 pd mid-frame still shifts
    run_frame(4'b1110, 1); model(4'b1110);
    chk("R9 auto_pd cleared by cs", 32'(apd_cs), 0);
    chk("R6 readout", 32'(rd), 32'(buf_m));
    chk("R2 pd set", 32'(pd4), 1);
    chk("R6 sdo low after 12", 32'(sdo12), 0);
    cs_n = 1'b1; wait_cyc(H);

    run_frame(4'b1111, 1);
    chk("R3 buffer kept in pd", 32'(rd), 32'(buf_m));
    cs_n = 1'b1; wait_cyc(H);

    // R8 abort during conversion
    result = 12'h123;
    run_frame(4'd3, 1); model(4'd3);
    chk("R8 conv started", 32'(eoc12), 0);
    wait_cyc(10);
    cs_n = 1'b1; wait_cyc(H);
    chk("R8 eoc high after abort", 32'(eoc), 1);
    run_frame(4'b1110, 1); model(4'b1110);
    chk("R8 buffer unchanged", 32'(rd), 32'(buf_m));
    cs_n = 1'b1; wait_cyc(H);

    // R7 continuous mode
    result = 12'h9E1;
    run_frame(4'd7, 1); model(4'd7);
    wait_eoc(cnt);
    buf_m = result;
    wait_cyc(3);
    chk("R7 msb at eoc rise", 32'(sdo), 1);
    result = 12'h3F0;
    run_frame(4'd2, 0); model(4'd2);
    chk("R7 continuous readout", 32'(rd), 32'h9E1);
    chk("R9 auto_pd cleared by ioclk", 32'(auto_pd), 0);
    wait_eoc(cnt);
    buf_m = result;
    wait_cyc(3);
    chk("R7 msb second", 32'(sdo), 0);
    cs_n = 1'b1; wait_cyc(H);

    // random frames
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 40; k++) begin
      int r;
      r = $urandom_range(0, 15);
      c = (r >= 14) ? 4'(r) : 4'($urandom_range(0, 13));
      result = 12'($urandom_range(0, 4095));
      old = buf_m;
      run_frame(c, 1);
      model(c);
      chk("R6 random readout", 32'(rd), 32'(old));
      chk("R3 random pd", 32'(pd4), 32'(pd_m));
      chk("R5 random conv", 32'(eoc12), converts(c) ? 0 : 1);
      if (converts(c)) begin
        if ($urandom_range(0, 4) == 0) begin
          wait_cyc(5);
          cs_n = 1'b1; wait_cyc(H);
          chk("R8 random abort", 32'(eoc), 1);
        end else begin
          wait_eoc(cnt);
          buf_m = result;
          chk("R5 random length", 32'(cnt <= CONV), 1);
        end
      end
      cs_n = 1'b1; wait_cyc(H);
    end
    finish_run();
  end
endmodule